// File: doc/BRIEF.md
# Single-Cycle RISC Subset Core

This block is a 32-bit processor that completes one instruction on every rising clock edge. It fetches a fixed-length 32-bit word from a small internal program store. It decodes the word, reads two operands from a 32-entry register file and computes a result in an adder/comparator unit. The result goes back to the register file or, for a store, to a small internal data store, and the next program address is chosen in the same cycle. The instruction set is deliberately narrow:

- register-form add, subtract, signed set-less-than and jump-through-register;
- load word, store word, add-immediate and signed set-less-than-immediate;
- branch-if-equal and branch-if-not-equal;
- an absolute jump.

Both internal stores are filled through a preload port, normally while reset is held. A combinational debug port reads back any register so that results can be observed. Opcodes and function codes outside the listed set change nothing except the program address, which steps to the next word.

Top module: `sc_core`

## Requirements
- R1: A synchronous, active-high reset sets the program address to 0 and clears every register to 0 at the next rising edge.
- R2: Every instruction that is not a branch or jump advances the program address by 4 at the rising edge that completes it.
- R3: With op field [31:26] = 0, function field [5:0] = 32 writes rs+rt and 34 writes rs−rt into the register named by bits [15:11]. Both wrap modulo 2^32 and raise no trap.
- R4: Function 42 (op 0) and op 10 write 1 when the first operand is less than the second in a signed comparison, and 0 otherwise. Op 10 compares against the sign-extended 16-bit immediate and writes the register named by bits [20:16].
- R5: Op 8 writes rs plus the sign-extended immediate [15:0] into the register named by bits [20:16].
- R6: Register 0 always reads as 0; any write to it is discarded.
- R7: Op 35 (load) and op 43 (store) use the byte address rs + sign-extended [15:0]. Bits [1:0] of that address are ignored and the next bits select the data word. A load writes the register named by [20:16], and a store writes that register's value to memory.
- R8: Op 4 branches when rs equals rt and op 5 when they differ. A taken branch sets the program address to PC+4 plus the sign-extended offset shifted left by 2. A branch that is not taken sets it to PC+4.
- R9: Op 2 sets the program address to {PC+4 [31:28], instr[25:0], 2'b00}.
- R10: Function 8 with op 0 sets the program address to the value of rs, so that a jump through register 31 returns to the address held there.
- R11: Any other op value, or op 0 with any other function code, writes no register and no memory and advances the program address by 4.
- R12: When `ld_en` is high, `ld_data` is written at the rising edge into word `ld_addr` of the program store (`ld_dmem` = 0) or of the data store (`ld_dmem` = 1).
- R13: `dbg_data` shows the current content of the register selected by `dbg_sel`, combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Preload write strobe |
| ld_dmem | input | 1 | Preload target: 0 program store, 1 data store |
| ld_addr | input | 6 | Preload word index |
| ld_data | input | 32 | Preload word value |
| dbg_sel | input | 5 | Register index for the debug read |
| dbg_data | output | 32 | Value of the selected register |
| pc_o | output | 32 | Current program address |

## Verification
Each instruction takes one cycle. A register or data word it writes is visible one rising edge after the instruction's fetch address is on `pc_o`, and the debug read shows it in the same cycle with no added latency. The bench sweeps the input of a doubling-loop program from 0 to 33, which covers the zero-input case and both wrap boundaries. Each run lasts far more cycles than the longest loop needs and ends in a self-jump. The bench checks the reset state one edge after the reset edge, and reads back all results at falling edges once the program address has settled on the halt word.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

    localparam int XLEN = 32;

    // primary opcodes
    localparam logic [5:0] OP_REG  = 6'd0;
    localparam logic [5:0] OP_JMP  = 6'd2;
    localparam logic [5:0] OP_BEQ  = 6'd4;
    localparam logic [5:0] OP_BNE  = 6'd5;
    localparam logic [5:0] OP_ADDI = 6'd8;
    localparam logic [5:0] OP_SLTI = 6'd10;
    localparam logic [5:0] OP_LW   = 6'd35;
    localparam logic [5:0] OP_SW   = 6'd43;

    // function codes under OP_REG
    localparam logic [5:0] FN_JR  = 6'd8;
    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_SLT = 6'd42;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_SLT
    } alu_op_e;

    typedef enum logic [2:0] {
        FLOW_SEQ,
        FLOW_BEQ,
        FLOW_BNE,
        FLOW_JUMP,
        FLOW_JREG
    } flow_e;

    typedef struct packed {
        logic    reg_we;
        logic    dst_is_rd;
        logic    use_imm;
        alu_op_e alu_op;
        logic    mem_rd;
        logic    mem_wr;
        flow_e   flow;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_core_pkg::*;
(
    input  logic [31:0] instr,
    output ctrl_t       ctrl
);

    logic [5:0] opcode;
    logic [5:0] fcode;

    assign opcode = instr[31:26];
    assign fcode  = instr[5:0];

    always_comb begin
        ctrl           = '0;
        ctrl.alu_op    = ALU_ADD;
        ctrl.flow      = FLOW_SEQ;
        unique case (opcode)
            OP_REG: begin
                ctrl.dst_is_rd = 1'b1;
                unique case (fcode)
                    FN_ADD: begin
                        ctrl.reg_we = 1'b1;
                        ctrl.alu_op = ALU_ADD;
                    end
                    FN_SUB: begin
                        ctrl.reg_we = 1'b1;
                        ctrl.alu_op = ALU_SUB;
                    end
                    FN_SLT: begin
                        ctrl.reg_we = 1'b1;
                        ctrl.alu_op = ALU_SLT;
                    end
                    FN_JR: begin
                        ctrl.flow = FLOW_JREG;
                    end
                    default: begin
                        ctrl.dst_is_rd = 1'b1;
                    end
                endcase
            end
            OP_JMP: begin
                ctrl.flow = FLOW_JUMP;
            end
            OP_BEQ: begin
                ctrl.flow = FLOW_BEQ;
            end
            OP_BNE: begin
                ctrl.flow = FLOW_BNE;
            end
            OP_ADDI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.alu_op  = ALU_ADD;
            end
            OP_SLTI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.alu_op  = ALU_SLT;
            end
            OP_LW: begin
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.mem_rd  = 1'b1;
            end
            OP_SW: begin
                ctrl.use_imm = 1'b1;
                ctrl.mem_wr  = 1'b1;
            end
            default: begin
                ctrl.flow = FLOW_SEQ;
            end
        endcase
    end

    // R11
    always_comb begin
        ctrl_excl_chk: assert ($onehot0({ctrl.mem_rd, ctrl.mem_wr, ctrl.flow != FLOW_SEQ}));
    end

    // R7
    always_comb begin
        store_nowb_chk: assert (!(ctrl.mem_wr && ctrl.reg_we));
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int NREG = 32,
    parameter int XLEN = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   ra_a,
    input  logic [AW-1:0]   ra_b,
    input  logic [AW-1:0]   ra_dbg,
    output logic [XLEN-1:0] rd_a,
    output logic [XLEN-1:0] rd_b,
    output logic [XLEN-1:0] rd_dbg,
    input  logic            we,
    input  logic [AW-1:0]   wa,
    input  logic [XLEN-1:0] wd
);

    logic [XLEN-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd_a   = regs[ra_a];
    assign rd_b   = regs[ra_b];
    assign rd_dbg = regs[ra_dbg];

    // R6
    x0_zero_chk: assert property (@(posedge clk) disable iff (rst)
        regs[0] == '0);

    // R3
    wr_land_chk: assert property (@(posedge clk) disable iff (rst)
        (we && (wa != '0)) |=> (regs[$past(wa)] == $past(wd)));

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  alu_op_e      op,
    output logic [W-1:0] res
);

    always_comb begin
        unique case (op)
            ALU_ADD: res = opa + opb;
            ALU_SUB: res = opa - opb;
            ALU_SLT: res = ($signed(opa) < $signed(opb)) ? W'(1) : '0;
            default: res = opa + opb;
        endcase
    end

    // R4
    always_comb begin
        if (op == ALU_SLT) begin
            slt_range_chk: assert (res[W-1:1] == '0);
        end
    end

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_core_pkg::*;
#(
    parameter int IMEM_AW = 6,
    parameter int DMEM_AW = 6,
    parameter int NREG    = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ld_en,
    input  logic        ld_dmem,
    input  logic [((IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW)-1:0] ld_addr,
    input  logic [31:0] ld_data,
    input  logic [$clog2(NREG)-1:0] dbg_sel,
    output logic [31:0] dbg_data,
    output logic [31:0] pc_o
);

    localparam int IWORDS = 1 << IMEM_AW;
    localparam int DWORDS = 1 << DMEM_AW;
    localparam int RAW    = $clog2(NREG);

    logic [XLEN-1:0] imem [IWORDS];
    logic [XLEN-1:0] dmem [DWORDS];

    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] pc_next;
    logic [XLEN-1:0] pc_plus4;
    logic [XLEN-1:0] br_target;
    logic [XLEN-1:0] instr;
    ctrl_t           ctrl;

    logic [RAW-1:0]  f_rs;
    logic [RAW-1:0]  f_rt;
    logic [RAW-1:0]  f_rd;
    logic [XLEN-1:0] imm_sx;
    logic [XLEN-1:0] rs_val;
    logic [XLEN-1:0] rt_val;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_y;
    logic [XLEN-1:0] ld_word;
    logic [XLEN-1:0] wb_val;
    logic [RAW-1:0]  wb_idx;
    logic [DMEM_AW-1:0] d_idx;
    logic            br_take;

    // fetch
    assign instr = imem[pc[IMEM_AW+1:2]];

    // field split
    assign f_rs   = instr[21+RAW-1:21];
    assign f_rt   = instr[16+RAW-1:16];
    assign f_rd   = instr[11+RAW-1:11];
    assign imm_sx = {{(XLEN-16){instr[15]}}, instr[15:0]};

    sc_decode u_dec (
        .instr (instr),
        .ctrl  (ctrl)
    );

    sc_regfile #(
        .NREG (NREG),
        .XLEN (XLEN)
    ) u_rf (
        .clk    (clk),
        .rst    (rst),
        .ra_a   (f_rs),
        .ra_b   (f_rt),
        .ra_dbg (dbg_sel),
        .rd_a   (rs_val),
        .rd_b   (rt_val),
        .rd_dbg (dbg_data),
        .we     (ctrl.reg_we && !rst),
        .wa     (wb_idx),
        .wd     (wb_val)
    );

    assign alu_b = ctrl.use_imm ? imm_sx : rt_val;

    sc_alu #(
        .W (XLEN)
    ) u_alu (
        .opa (rs_val),
        .opb (alu_b),
        .op  (ctrl.alu_op),
        .res (alu_y)
    );

    // data access
    assign d_idx   = alu_y[DMEM_AW+1:2];
    assign ld_word = dmem[d_idx];
    assign wb_val  = ctrl.mem_rd ? ld_word : alu_y;
    assign wb_idx  = ctrl.dst_is_rd ? f_rd : f_rt;

    always_ff @(posedge clk) begin
        if (ld_en && !ld_dmem) begin
            imem[ld_addr[IMEM_AW-1:0]] <= ld_data;
        end
    end

    always_ff @(posedge clk) begin
        if (ld_en && ld_dmem) begin
            dmem[ld_addr[DMEM_AW-1:0]] <= ld_data;
        end else if (!rst && ctrl.mem_wr) begin
            dmem[d_idx] <= rt_val;
        end
    end

    // next address
    assign pc_plus4  = pc + 32'd4;
    assign br_target = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};

    always_comb begin
        br_take = 1'b0;
        pc_next = pc_plus4;
        unique case (ctrl.flow)
            FLOW_SEQ:  pc_next = pc_plus4;
            FLOW_BEQ: begin
                br_take = (rs_val == rt_val);
                pc_next = br_take ? br_target : pc_plus4;
            end
            FLOW_BNE: begin
                br_take = (rs_val != rt_val);
                pc_next = br_take ? br_target : pc_plus4;
            end
            FLOW_JUMP: pc_next = {pc_plus4[31:28], instr[25:0], 2'b00};
            FLOW_JREG: pc_next = rs_val;
            default:   pc_next = pc_plus4;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else begin
            pc <= pc_next;
        end
    end

    assign pc_o = pc;

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.flow == FLOW_SEQ) |=> (pc == $past(pc) + 32'd4));

    // R8
    br_taken_chk: assert property (@(posedge clk) disable iff (rst)
        ((ctrl.flow == FLOW_BEQ) && (rs_val == rt_val))
        |=> (pc == $past(pc) + 32'd4 + ($past(imm_sx) << 2)));

    // R8
    br_fall_chk: assert property (@(posedge clk) disable iff (rst)
        ((ctrl.flow == FLOW_BNE) && (rs_val == rt_val))
        |=> (pc == $past(pc) + 32'd4));

    // R10
    jreg_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.flow == FLOW_JREG) |=> (pc == $past(rs_val)));

    // R7
    store_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mem_wr && !ld_en) |=> (dmem[$past(d_idx)] == $past(rt_val)));

endmodule

// File: tb/sc_core_test.sv
module sc_core_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic        ld_dmem = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [4:0]  dbg_sel = '0;
    logic [31:0] dbg_data;
    logic [31:0] pc_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    sc_core uut (
        .clk      (clk),
        .rst      (rst),
        .ld_en    (ld_en),
        .ld_dmem  (ld_dmem),
        .ld_addr  (ld_addr),
        .ld_data  (ld_data),
        .dbg_sel  (dbg_sel),
        .dbg_data (dbg_data),
        .pc_o     (pc_o)
    );

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction

    function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    function automatic logic [31:0] enc_j(int tgt);
        return {6'd2, 26'(tgt)};
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h want %h", req, what, act, exp);
        end
    endtask

    task automatic put(logic sel, int addr, logic [31:0] val);
        @(negedge clk);
        ld_en   = 1'b1;
        ld_dmem = sel;
        ld_addr = 6'(addr);
        ld_data = val;
        @(negedge clk);
        ld_en   = 1'b0;
    endtask

    task automatic peek(int idx, output logic [31:0] val);
        dbg_sel = 5'(idx);
        #1;
        val = dbg_data;
    endtask

    task automatic load_program();
        put(0, 0,  enc_i(35, 0, 4, 0));        // lw   r4,0(r0)
        put(0, 1,  enc_i(8, 0, 8, 1));         // addi r8,r0,1
        put(0, 2,  enc_r(0, 0, 9, 32));        // add  r9,r0,r0
        put(0, 3,  enc_r(9, 4, 10, 42));       // slt  r10,r9,r4
        put(0, 4,  enc_i(4, 10, 0, 3));        // beq  r10,r0,+3 -> 8
        put(0, 5,  enc_r(8, 8, 8, 32));        // add  r8,r8,r8
        put(0, 6,  enc_i(8, 9, 9, 1));         // addi r9,r9,1
        put(0, 7,  enc_j(3));                  // j    3
        put(0, 8,  enc_r(0, 8, 2, 32));        // add  r2,r0,r8
        put(0, 9,  enc_i(43, 0, 2, 4));        // sw   r2,4(r0)
        put(0, 10, enc_i(35, 0, 11, 4));       // lw   r11,4(r0)
        put(0, 11, enc_i(8, 0, 31, 56));       // addi r31,r0,56
        put(0, 12, enc_r(31, 0, 0, 8));        // jr   r31 -> 14
        put(0, 13, enc_i(8, 0, 12, 99));       // skipped
        put(0, 14, enc_i(5, 0, 0, 5));         // bne  r0,r0 not taken
        put(0, 15, enc_r(0, 8, 13, 34));       // sub  r13,r0,r8
        put(0, 16, enc_i(10, 13, 14, 0));      // slti r14,r13,0
        put(0, 17, enc_r(8, 13, 15, 42));      // slt  r15,r8,r13
        put(0, 18, enc_i(8, 0, 0, 5));         // addi r0,r0,5
        put(0, 19, {6'h3F, 5'd0, 5'd16, 16'h0001}); // unlisted opcode
        put(0, 20, enc_r(8, 8, 17, 63));       // unlisted function code
        put(0, 21, enc_i(5, 8, 0, 1));         // bne  r8,r0,+1 -> 23
        put(0, 22, enc_i(8, 0, 18, 7));        // addi r18,r0,7
        put(0, 23, enc_j(23));                 // halt
    endtask

    initial begin
        #1_200_000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout want completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] p2;
        logic [31:0] ng;
        for (int y = 0; y <= 33; y++) begin
            @(negedge clk);
            rst = 1'b1;
            load_program();               // R12: program store preload
            put(1, 0, 32'(y));            // R12: data store preload
            put(1, 1, 32'hFFFF_FFFF);
            // R1: reset state, registers dirty from the previous run
            check("R1", "pc after reset", pc_o, 32'd0);
            peek(8, v);  check("R1", "r8 after reset", v, 32'd0);
            peek(31, v); check("R1", "r31 after reset", v, 32'd0);
            @(negedge clk);
            rst = 1'b0;
            repeat (400) @(negedge clk);

            p2 = (y < 32) ? (32'd1 << y) : 32'd0;
            ng = 32'd0 - p2;
            check("R9", "halt pc", pc_o, 32'd92);
            peek(2, v);  check("R3", "doubled result r2", v, p2);
            peek(8, v);  check("R8", "loop value r8", v, p2);
            peek(4, v);  check("R7", "loaded input r4", v, 32'(y));
            peek(9, v);  check("R5", "counter r9", v, 32'(y));
            peek(10, v); check("R4", "loop exit slt r10", v, 32'd0);
            peek(11, v); check("R7", "store then load r11", v, p2);
            peek(31, v); check("R10", "return reg r31", v, 32'd56);
            peek(12, v); check("R10", "skipped word r12", v, 32'd0);
            peek(13, v); check("R3", "sub wrap r13", v, ng);
            peek(14, v); check("R4", "slti r14", v, ($signed(ng) < 0) ? 32'd1 : 32'd0);
            peek(15, v); check("R4", "slt r15", v, ($signed(p2) < $signed(ng)) ? 32'd1 : 32'd0);
            peek(0, v);  check("R6", "r0 after write", v, 32'd0);
            peek(16, v); check("R11", "unlisted op r16", v, 32'd0);
            peek(17, v); check("R11", "unlisted funct r17", v, 32'd0);
            peek(18, v); check("R8", "bne path r18", v, (p2 == 0) ? 32'd7 : 32'd0);
            peek(13, v); check("R13", "debug read r13 again", v, ng);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule